// File: doc/BRIEF.md
# Overlapped Load-Store Core with Shared Memory Port

A compact register-based processor core that keeps one instruction in fetch while the previous one executes. Arithmetic instructions work only on the sixteen registers and finish in the execute slot. Loads and stores are the only instructions that touch memory. They compute their address in the execute slot and then take one further cycle for the data transfer.

In the default build, one memory port serves both instruction fetch and data transfer. The transfer always wins that port, so fetch waits and a bubble enters the overlapped schedule. The `DUAL_PORT` parameter adds a separate fetch port so that both accesses happen in the same cycle. The `retired_cnt` and `cycle_cnt` outputs show the resulting cycles-per-instruction.

Instructions are 32 bits wide. Jumps and equality branches redirect fetch and throw away the instruction already fetched behind them. A halt instruction freezes the core.

Top module: `lsc_core`

## Requirements
- R1: After reset the program counter is 0 and the fetched-instruction register is empty. In the first cycle after reset the core only fetches: `mem_addr` shows 0, `mem_we` is low, and both counters read 0.
- R2: The instruction word holds the opcode in bits 31:28, rd in 27:24, rs1 in 23:20, rs2 in 19:16 and a 16-bit immediate in 15:0. ADD (1), SUB (2) and MUL (3) write rs1 op rs2 (the low 32 bits) to rd. Register 0 always reads zero, and any write to it is dropped.
- R3: ADDI (4) writes rs1 plus the sign-extended immediate to rd.
- R4: LD (5) loads rd from address rs1 plus the sign-extended immediate, and ST (6) writes rs2 to that address. An offset of 0 gives register-indirect addressing, and a base of register 0 gives an absolute address. Only these two opcodes ever drive a memory write.
- R5: An instruction that reads the register a load is still transferring waits one cycle and then sees the loaded value. This also holds for store data.
- R6: With one port, each data transfer takes the port and fetch waits. A straight-line program of N instructions ending in HALT, containing M loads/stores each followed by at least two more instructions and no load-use pairs, takes N+1+M cycles.
- R7: With `DUAL_PORT` set, the same program takes N+1 cycles.
- R8: JMP (7) continues at the address in the low immediate bits. The sequential instruction already fetched behind it never executes.
- R9: BEQ (8) branches to the immediate address, discarding the sequential fetch, when rs1 equals rs2. Otherwise it falls through.
- R10: HALT (15) stops fetch and the cycle counter, and no memory writes follow it. Opcode 0 and unused codes do nothing.
- R11: `retired_cnt` counts every completed instruction, HALT included. `cycle_cnt` counts the cycles from reset release through the cycle that executes HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Word address of the shared or data port |
| mem_we | output | 1 | Write strobe for a store transfer |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Combinational read data of the shared or data port |
| fetch_addr | output | ADDR_W | Fetch address in dual-port mode, 0 otherwise |
| fetch_rdata | input | DATA_W | Instruction word in dual-port mode |
| halted | output | 1 | High once HALT has executed |
| retired_cnt | output | CNT_W | Completed instruction count |
| cycle_cnt | output | CNT_W | Cycles run since reset |

## Verification
The hardest situation to reach is a load in its transfer cycle while the next instruction, which depends on it, sits in execute and fetch is also locked out of the port. A close second is a jump whose sequential successor has already been fetched. Both come from the ordering of hand-built programs. A load is followed directly by a dependent add, and a load is followed directly by a store of the loaded register. Jumps and taken branches are placed in front of stores that must never appear on the port. The same programs run on a single-port and a dual-port instance side by side, and the exact cycle totals expose every bubble.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 4;
    localparam int IMM_W     = 16;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_ADDI = 4'd4,
        OP_LD   = 4'd5,
        OP_ST   = 4'd6,
        OP_JMP  = 4'd7,
        OP_BEQ  = 4'd8,
        OP_HALT = 4'd15
    } opcode_e;

    typedef struct packed {
        opcode_e                opc;
        logic [REG_IDX_W-1:0]   rd;
        logic [REG_IDX_W-1:0]   rs1;
        logic [REG_IDX_W-1:0]   rs2;
        logic [IMM_W-1:0]       imm;
    } instr_t;

    function automatic logic is_xfer(opcode_e o);
        return (o == OP_LD) || (o == OP_ST);
    endfunction

    function automatic logic reads_src1(opcode_e o);
        case (o)
            OP_ADD, OP_SUB, OP_MUL, OP_ADDI, OP_LD, OP_ST, OP_BEQ: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reads_src2(opcode_e o);
        case (o)
            OP_ADD, OP_SUB, OP_MUL, OP_ST, OP_BEQ: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic alu_writes(opcode_e o);
        case (o)
            OP_ADD, OP_SUB, OP_MUL, OP_ADDI: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rsel_a,
    input  logic [IDX_W-1:0]  rsel_b,
    output logic [DATA_W-1:0] rval_a,
    output logic [DATA_W-1:0] rval_b,
    // older writer: load data from the transfer slot
    input  logic              old_we,
    input  logic [IDX_W-1:0]  old_idx,
    input  logic [DATA_W-1:0] old_data,
    // younger writer: ALU result from the execute slot, wins on a tie
    input  logic              new_we,
    input  logic [IDX_W-1:0]  new_idx,
    input  logic [DATA_W-1:0] new_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else begin
            if (old_we && old_idx != '0) regs[old_idx] <= old_data;
            if (new_we && new_idx != '0) regs[new_idx] <= new_data;
        end
    end

    assign rval_a = (rsel_a == '0) ? '0 : regs[rsel_a];
    assign rval_b = (rsel_b == '0) ? '0 : regs[rsel_b];

endmodule

// File: rtl/lsc_exec.sv
module lsc_exec
    import lsc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  instr_t            ins,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              redirect,
    output logic [ADDR_W-1:0] target
);
    logic [DATA_W-1:0] imm_sx;

    assign imm_sx = {{(DATA_W-IMM_W){ins.imm[IMM_W-1]}}, ins.imm};

    always_comb begin
        case (ins.opc)
            OP_ADD:  result = src_a + src_b;
            OP_SUB:  result = src_a - src_b;
            OP_MUL:  result = src_a * src_b;
            OP_ADDI: result = src_a + imm_sx;
            default: result = '0;
        endcase
    end

    assign eff_addr = ADDR_W'(src_a + imm_sx);
    assign target   = ins.imm[ADDR_W-1:0];
    assign redirect = (ins.opc == OP_JMP) || ((ins.opc == OP_BEQ) && (src_a == src_b));

endmodule

// File: rtl/lsc_fetch.sv
module lsc_fetch
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_busy,
    input  logic              consume,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    input  logic              halt_req,
    input  instr_t            fetch_word,
    output logic [ADDR_W-1:0] pc,
    output instr_t            ir,
    output logic              ir_valid,
    output logic              halted
);
    logic can_fetch;

    assign can_fetch = !halted && !port_busy && (!ir_valid || consume);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ir       <= '0;
            ir_valid <= 1'b0;
            halted   <= 1'b0;
        end else if (halt_req) begin
            halted   <= 1'b1;
            ir_valid <= 1'b0;
        end else if (redirect) begin
            pc       <= target;
            ir_valid <= 1'b0;
        end else if (can_fetch) begin
            ir       <= fetch_word;
            ir_valid <= 1'b1;
            pc       <= pc + 1'b1;
        end else if (consume) begin
            ir_valid <= 1'b0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && !ir_valid && !halted));

    // R6
    fetch_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (port_busy && !redirect && !halt_req) |=> $stable(pc));

    // R8
    discard_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !ir_valid);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !ir_valid && $stable(pc)));

endmodule

// File: rtl/lsc_core.sv
module lsc_core
    import lsc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 16,
    parameter bit DUAL_PORT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_rdata,
    output logic              halted,
    output logic [CNT_W-1:0]  retired_cnt,
    output logic [CNT_W-1:0]  cycle_cnt
);
    // fetch / execute
    logic [ADDR_W-1:0] pc;
    instr_t            ir;
    logic              ir_valid;
    instr_t            fetch_word;
    logic              port_busy;
    logic              load_use;
    logic              ex_go;
    logic              ex_redirect;
    logic              take_branch;
    logic              halt_now;
    logic [DATA_W-1:0] src_a, src_b, alu_res;
    logic [ADDR_W-1:0] eff_addr, br_target;

    // transfer slot
    logic              x_valid;
    logic              x_load;
    logic [REG_IDX_W-1:0] x_rd;
    logic [ADDR_W-1:0] x_ea;
    logic [DATA_W-1:0] x_wdata;

    assign fetch_word = instr_t'(DUAL_PORT ? fetch_rdata[INSTR_W-1:0] : mem_rdata[INSTR_W-1:0]);

    generate
        if (DUAL_PORT) begin : g_dual
            assign port_busy  = 1'b0;
            assign fetch_addr = pc;
            assign mem_addr   = x_ea;
        end else begin : g_single
            assign port_busy  = x_valid;
            assign fetch_addr = '0;
            assign mem_addr   = x_valid ? x_ea : pc;
        end
    endgenerate

    assign mem_we    = x_valid && !x_load;
    assign mem_wdata = x_wdata;

    assign load_use = ir_valid && x_valid && x_load && (x_rd != '0) &&
                      ((reads_src1(ir.opc) && ir.rs1 == x_rd) ||
                       (reads_src2(ir.opc) && ir.rs2 == x_rd));
    assign ex_go       = ir_valid && !load_use;
    assign ex_redirect = ex_go && take_branch;
    assign halt_now    = ex_go && (ir.opc == OP_HALT);

    lsc_regfile #(.DATA_W(DATA_W), .IDX_W(REG_IDX_W)) rf_i (
        .clk      (clk),
        .rst      (rst),
        .rsel_a   (ir.rs1),
        .rsel_b   (ir.rs2),
        .rval_a   (src_a),
        .rval_b   (src_b),
        .old_we   (x_valid && x_load),
        .old_idx  (x_rd),
        .old_data (mem_rdata),
        .new_we   (ex_go && alu_writes(ir.opc)),
        .new_idx  (ir.rd),
        .new_data (alu_res)
    );

    lsc_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ex_i (
        .ins      (ir),
        .src_a    (src_a),
        .src_b    (src_b),
        .result   (alu_res),
        .eff_addr (eff_addr),
        .redirect (take_branch),
        .target   (br_target)
    );

    lsc_fetch #(.ADDR_W(ADDR_W)) fe_i (
        .clk        (clk),
        .rst        (rst),
        .port_busy  (port_busy),
        .consume    (ex_go),
        .redirect   (ex_redirect),
        .target     (br_target),
        .halt_req   (halt_now),
        .fetch_word (fetch_word),
        .pc         (pc),
        .ir         (ir),
        .ir_valid   (ir_valid),
        .halted     (halted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_valid <= 1'b0;
            x_load  <= 1'b0;
            x_rd    <= '0;
            x_ea    <= '0;
            x_wdata <= '0;
        end else begin
            x_valid <= ex_go && is_xfer(ir.opc);
            if (ex_go) begin
                x_load  <= (ir.opc == OP_LD);
                x_rd    <= ir.rd;
                x_ea    <= eff_addr;
                x_wdata <= src_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            retired_cnt <= '0;
            cycle_cnt   <= '0;
        end else begin
            if (!halted) cycle_cnt <= cycle_cnt + 1'b1;
            retired_cnt <= retired_cnt + CNT_W'(ex_go && !is_xfer(ir.opc)) + CNT_W'(x_valid);
        end
    end

    // R5
    load_use_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load_use |=> (ir_valid && !x_valid));

    // R11
    retire_bound_chk: assert property (@(posedge clk) disable iff (rst)
        retired_cnt <= cycle_cnt);

    // R4
    store_only_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(ex_go && ir.opc == OP_ST));

endmodule

// File: tb/lsc_core_tb.sv
`timescale 1ns/1ps
module lsc_core_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [7:0]  s_addr, s_faddr, d_addr, d_faddr;
    logic        s_we, d_we, s_halted, d_halted;
    logic [31:0] s_wdata, s_rdata, s_frdata, d_wdata, d_rdata, d_frdata;
    logic [15:0] s_ret, s_cyc, d_ret, d_cyc;

    logic [31:0] img   [256];
    logic [31:0] mem_s [256];
    logic [31:0] mem_d [256];

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  qa_s[$], qa_d[$];
    logic [31:0] qd_s[$], qd_d[$];
    string       qt_s[$], qt_d[$];

    lsc_core #(.DATA_W(32), .ADDR_W(8), .CNT_W(16), .DUAL_PORT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .mem_addr(s_addr), .mem_we(s_we), .mem_wdata(s_wdata),
        .mem_rdata(s_rdata), .fetch_addr(s_faddr), .fetch_rdata(s_frdata),
        .halted(s_halted), .retired_cnt(s_ret), .cycle_cnt(s_cyc));

    lsc_core #(.DATA_W(32), .ADDR_W(8), .CNT_W(16), .DUAL_PORT(1'b1)) dut_dual_i (
        .clk(clk), .rst(rst), .mem_addr(d_addr), .mem_we(d_we), .mem_wdata(d_wdata),
        .mem_rdata(d_rdata), .fetch_addr(d_faddr), .fetch_rdata(d_frdata),
        .halted(d_halted), .retired_cnt(d_ret), .cycle_cnt(d_cyc));

    assign s_rdata  = mem_s[s_addr];
    assign s_frdata = mem_s[s_faddr];
    assign d_rdata  = mem_d[d_addr];
    assign d_frdata = mem_d[d_faddr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                mem_s[i] <= img[i];
                mem_d[i] <= img[i];
            end
        end else begin
            if (s_we) mem_s[s_addr] <= s_wdata;
            if (d_we) mem_d[d_addr] <= d_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs1, input logic [3:0] rs2,
                                        input logic [15:0] imm);
        return {op, rd, rs1, rs2, imm};
    endfunction

    // driver: push one expected store for both instances
    task automatic expect_store(input logic [7:0] a, input logic [31:0] d, input string tag);
        qa_s.push_back(a); qd_s.push_back(d); qt_s.push_back(tag);
        qa_d.push_back(a); qd_d.push_back(d); qt_d.push_back(tag);
    endtask

    // monitor: pop and compare each store as it appears on the port
    always @(negedge clk) begin
        if (!rst && s_we) begin
            if (qa_s.size() == 0) chk(1'b0, "R10", "single unexpected store", {24'd0, s_addr}, 32'd0);
            else begin
                logic [7:0] ea; logic [31:0] ed; string t;
                ea = qa_s.pop_front(); ed = qd_s.pop_front(); t = qt_s.pop_front();
                chk(s_addr == ea, t, "single store addr", {24'd0, s_addr}, {24'd0, ea});
                chk(s_wdata == ed, t, "single store data", s_wdata, ed);
            end
        end
        if (!rst && d_we) begin
            if (qa_d.size() == 0) chk(1'b0, "R10", "dual unexpected store", {24'd0, d_addr}, 32'd0);
            else begin
                logic [7:0] ea; logic [31:0] ed; string t;
                ea = qa_d.pop_front(); ed = qd_d.pop_front(); t = qt_d.pop_front();
                chk(d_addr == ea, t, "dual store addr", {24'd0, d_addr}, {24'd0, ea});
                chk(d_wdata == ed, t, "dual store data", d_wdata, ed);
            end
        end
    end

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 32'd0;
    endtask

    task automatic run_prog(input int exp_ret, input bit chk_cyc,
                            input int exp_cs, input int exp_cd);
        logic [15:0] cs, cd;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after reset is a pure fetch from 0
        chk(s_addr == 8'd0 && !s_we, "R1", "single port after reset", {23'd0, s_we, s_addr}, 32'd0);
        chk(!d_we && d_faddr == 8'd0, "R1", "dual port after reset", {23'd0, d_we, d_faddr}, 32'd0);
        chk(s_ret == 0 && s_cyc == 0 && d_ret == 0 && d_cyc == 0, "R1", "counters after reset",
            {s_ret, s_cyc}, 32'd0);
        for (int k = 0; k < 500 && !(s_halted && d_halted); k++) @(negedge clk);
        chk(s_halted && d_halted, "R10", "both halted", {30'd0, s_halted, d_halted}, 32'd3);
        cs = s_cyc; cd = d_cyc;
        repeat (6) @(negedge clk);
        chk(s_cyc == cs && d_cyc == cd, "R10", "cycle counter frozen", {s_cyc, d_cyc}, {cs, cd});
        chk(qa_s.size() == 0 && qa_d.size() == 0, "R4", "all stores seen",
            qa_s.size() + qa_d.size(), 32'd0);
        chk(s_ret == 16'(exp_ret), "R11", "single retired", {16'd0, s_ret}, exp_ret);
        chk(d_ret == 16'(exp_ret), "R11", "dual retired", {16'd0, d_ret}, exp_ret);
        if (chk_cyc) begin
            chk(s_cyc == 16'(exp_cs), "R6", "single-port cycles N+1+M", {16'd0, s_cyc}, exp_cs);
            chk(d_cyc == 16'(exp_cd), "R7", "dual-port cycles N+1", {16'd0, d_cyc}, exp_cd);
        end
    endtask

    initial begin
        // program A: straight-line arithmetic and addressing (R2 R3 R4 R6 R7)
        clear_img();
        img[8'h80] = 32'd7;
        img[8'h81] = 32'hFFFF_FFFD;
        img[0]  = enc(4'd4,  4'd1,  4'd0, 4'd0,  16'h0080);
        img[1]  = enc(4'd5,  4'd2,  4'd1, 4'd0,  16'h0000);
        img[2]  = enc(4'd5,  4'd3,  4'd1, 4'd0,  16'h0001);
        img[3]  = enc(4'd4,  4'd4,  4'd2, 4'd0,  16'hFFF6);
        img[4]  = enc(4'd1,  4'd5,  4'd2, 4'd3,  16'h0000);
        img[5]  = enc(4'd2,  4'd6,  4'd2, 4'd3,  16'h0000);
        img[6]  = enc(4'd3,  4'd7,  4'd5, 4'd6,  16'h0000);
        img[7]  = enc(4'd6,  4'd0,  4'd1, 4'd7,  16'h0002);
        img[8]  = enc(4'd3,  4'd8,  4'd3, 4'd4,  16'h0000);
        img[9]  = enc(4'd6,  4'd0,  4'd0, 4'd8,  16'h0083);
        img[10] = enc(4'd2,  4'd9,  4'd0, 4'd2,  16'h0000);
        img[11] = enc(4'd6,  4'd0,  4'd1, 4'd9,  16'hFFFF);
        img[12] = enc(4'd6,  4'd0,  4'd1, 4'd4,  16'h0004);
        img[13] = enc(4'd1,  4'd11, 4'd5, 4'd6,  16'h0000);
        img[14] = enc(4'd6,  4'd0,  4'd1, 4'd11, 16'h0005);
        img[15] = enc(4'd4,  4'd12, 4'd0, 4'd0,  16'h0001);
        img[16] = enc(4'd0,  4'd0,  4'd0, 4'd0,  16'h0000);
        img[17] = enc(4'd15, 4'd0,  4'd0, 4'd0,  16'h0000);
        expect_store(8'h82, 32'd40,         "R2");  // (7 + -3) * (7 - -3)
        expect_store(8'h83, 32'd9,          "R2");  // MUL of negatives, absolute address
        expect_store(8'h7F, 32'hFFFF_FFF9,  "R4");  // r0 - 7, negative offset
        expect_store(8'h84, 32'hFFFF_FFFD,  "R3");  // 7 + sign-extended -10
        expect_store(8'h85, 32'd14,         "R2");
        // N = 18, M = 7
        run_prog(18, 1'b1, 26, 19);

        // program B: hazards and control flow (R5 R8 R9 R10 R2)
        clear_img();
        img[8'h90] = 32'd5;
        img[0]  = enc(4'd4,  4'd1, 4'd0, 4'd0, 16'h0090);
        img[1]  = enc(4'd5,  4'd2, 4'd1, 4'd0, 16'h0000);
        img[2]  = enc(4'd4,  4'd3, 4'd2, 4'd0, 16'h0001);
        img[3]  = enc(4'd6,  4'd0, 4'd1, 4'd3, 16'h0001);
        img[4]  = enc(4'd4,  4'd0, 4'd0, 4'd0, 16'h0009);
        img[5]  = enc(4'd6,  4'd0, 4'd1, 4'd0, 16'h0002);
        img[6]  = enc(4'd7,  4'd0, 4'd0, 4'd0, 16'h0009);
        img[7]  = enc(4'd6,  4'd0, 4'd1, 4'd2, 16'h0003);
        img[8]  = enc(4'd6,  4'd0, 4'd1, 4'd2, 16'h0004);
        img[9]  = enc(4'd8,  4'd0, 4'd2, 4'd3, 16'h000C);
        img[10] = enc(4'd6,  4'd0, 4'd1, 4'd3, 16'h0005);
        img[11] = enc(4'd8,  4'd0, 4'd2, 4'd2, 16'h000E);
        img[12] = enc(4'd6,  4'd0, 4'd1, 4'd2, 16'h0006);
        img[13] = enc(4'd15, 4'd0, 4'd0, 4'd0, 16'h0000);
        img[14] = enc(4'd5,  4'd4, 4'd1, 4'd0, 16'h0000);
        img[15] = enc(4'd6,  4'd0, 4'd1, 4'd4, 16'h0007);
        img[16] = enc(4'd15, 4'd0, 4'd0, 4'd0, 16'h0000);
        expect_store(8'h91, 32'd6, "R5");  // load-use: 5 + 1
        expect_store(8'h92, 32'd0, "R2");  // write to register 0 dropped
        expect_store(8'h95, 32'd6, "R9");  // branch not taken falls through; jump skipped 0x93/0x94 (R8)
        expect_store(8'h97, 32'd5, "R5");  // load feeding store data; taken branch skipped 0x96
        run_prog(13, 1'b0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual no halt expected halt");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule